// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking in-memory translation tables. A walk starts from a context table: the table base register and the current context number pick one word there. The walk then follows pointer entries through up to three table levels. A leaf entry may appear at the first, second or third level, so one walk maps a 16 MB, 256 KB or 4 KB page. The walker fetches one descriptor word at a time over a simple request/acknowledge word port. It decodes the two type bits of each word. It returns either the physical address with the entry's access field or a fault code that records the level where it stopped.

When a leaf is reached and its referenced bit is clear, or the access is a write and its modified bit is clear, the walker sets those bits and writes the word back to the address it was read from. The walk ends only after that write. With translation disabled, the address passes straight through and no table is read. In that case a boot option sends instruction fetches into a boot-ROM window. The walker runs one walk at a time and shows this on a busy output. It pulses done once for each accepted request.

Top module: `xlat_walker`

## Requirements
- R1: After a synchronous active-low reset, busy, done and mem_req are all low.
- R2: The first descriptor is read at address (cfg_root << 4) + (cfg_ctx << 2). Each later descriptor is read at (entry with bits 1:0 cleared) << 4 plus four times an index. The index is VA[31:24] at the first level, VA[23:18] at the second and VA[17:12] at the third.
- R3: Entry bits 1:0 give its type: 0 invalid, 1 pointer, 2 leaf, 3 reserved. The walker reads exactly one word per level it visits. It follows pointers at the context level and at levels 1 and 2.
- R4: A leaf at level 1, 2 or 3 gives rsp_level equal to that level. rsp_paddr is then (entry[31:8] << 12) plus VA[23:0], VA[17:0] or VA[11:0] respectively.
- R5: On a fault, rsp_fault is high and rsp_code is (level << 8) | (kind << 2), with level 0 for the context table. Kind 1 means an invalid entry. Kind 4 means a reserved entry, a leaf in the context table or a pointer at level 3.
- R6: A leaf whose bit 5 (referenced) is clear, or whose bit 6 (modified) is clear on a write request, is written back once to its own address. The written value has bit 5 set, and bit 6 also set for a write. No other walk writes memory.
- R7: With cfg_enable low and no boot redirect, rsp_paddr is the zero-extended virtual address and rsp_kind is 1 (full permission). No memory access is made.
- R8: With cfg_enable low, cfg_boot high and req_fetch high, rsp_paddr is cfg_prom_base OR VA[18:0] and rsp_kind is 2 (read/execute only). A walk result has rsp_kind 0.
- R9: A request is taken only while busy is low. A request raised during a walk changes neither that walk's result nor its memory traffic, and produces no extra done.
- R10: mem_req, mem_we, mem_addr and mem_wdata stay unchanged until mem_ack is seen. The memory port is idle whenever busy is low.
- R11: done is a one-cycle pulse. It is registered on the accepting edge for a pass-through, and on the edge of the last memory handshake for a walk. busy falls with it.
- R12: For a leaf, rsp_acc equals entry bits 4:2 as read, before any write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Translation enable |
| cfg_boot | input | 1 | Boot redirect of fetches while translation is off |
| cfg_root | input | 32 | Context table base, in units of 16 bytes |
| cfg_ctx | input | CTX_W | Current context number |
| cfg_prom_base | input | 36 | Boot ROM window base |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| req_fetch | input | 1 | Request is an instruction fetch |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_code | output | 10 | Fault code (level << 8 \| kind << 2) |
| rsp_kind | output | 2 | 0 walked, 1 full pass-through, 2 boot window |
| rsp_level | output | 2 | Level of the leaf (1 to 3), 0 otherwise |
| rsp_acc | output | 3 | Access field of the leaf |
| rsp_paddr | output | 36 | Physical address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 36 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes on this edge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The bench counts clock edges from the edge that accepts a request and samples outputs on the falling edge in between. A pass-through result is due one edge after acceptance. A walk result is due after 1 + (reads + write-back) × (stall + 1) edges, where the bench's memory model adds a fixed stall before each acknowledge. Each vector states its expected read count, last descriptor address and write-back. The bench checks done exactly at that edge count, together with the read and write traffic seen at the port.

// File: rtl/xlat_walker_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 32-bit descriptor words whose address field shifted left by 4
// gives a 36-bit physical byte address.
package xlat_walker_pkg;
    localparam int ENT_W    = 32;
    localparam int VA_W     = 32;
    localparam int PA_W     = ENT_W + 4;
    localparam int ROOT_W   = PA_W - 4;
    localparam int CODE_W   = 10;
    localparam int LVL_W    = 2;
    localparam int ACC_W    = 3;
    localparam int PPN_LO   = 8;
    localparam int PPN_W    = ENT_W - PPN_LO;
    localparam int PTR_W    = ENT_W - 2;
    localparam int BIT_REF  = 5;
    localparam int BIT_MOD  = 6;
    localparam int ACC_LO   = 2;
    localparam int LAST_LVL = 3;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_PTR     = 2'd1,
        ET_LEAF    = 2'd2,
        ET_RSVD    = 2'd3
    } ent_type_e;

    typedef enum logic [1:0] {
        RK_WALK = 2'd0,
        RK_FULL = 2'd1,
        RK_BOOT = 2'd2
    } rsp_kind_e;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_READ  = 2'd1,
        WS_WRITE = 2'd2
    } walk_state_e;

    localparam logic [2:0] FK_INVALID = 3'd1;
    localparam logic [2:0] FK_ERROR   = 3'd4;
endpackage

// File: rtl/xlat_addr_gen.sv
// Descriptor address generator.
// Gives the context-table word address and the address of the next-level
// word from a pointer entry and the virtual address slice for that level.
// Assumes lvl_next is 1, 2 or 3 when next_addr is used.
module xlat_addr_gen
    import xlat_walker_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [ROOT_W-1:0] root,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [LVL_W-1:0]  lvl_next,
    input  logic [VA_W-1:12]  va_hi,
    output logic [PA_W-1:0]   ctx_addr,
    output logic [PA_W-1:0]   next_addr
);
    localparam int IDX_W = 8;

    logic [IDX_W-1:0] idx;

    // Pick the table index for the level being entered.
    always_comb begin
        case (lvl_next)
            2'd1:    idx = va_hi[31:24];
            2'd2:    idx = {2'b00, va_hi[23:18]};
            default: idx = {2'b00, va_hi[17:12]};
        endcase
    end

    // Context word: table base plus four bytes per context.
    assign ctx_addr  = {root, 4'b0000} + PA_W'({ctx, 2'b00});

    // Next-level word: cleared pointer scaled by 16 plus four bytes per index.
    assign next_addr = {ptr, 2'b00, 4'b0000} + PA_W'({idx, 2'b00});
endmodule

// File: rtl/xlat_entry_dec.sv
// Descriptor decoder.
// Classifies the word just read at a given level: descend, leaf or fault.
// Builds the fault code and the write-back word for referenced/modified.
// Assumes lvl is 0 (context table) to 3.
module xlat_entry_dec
    import xlat_walker_pkg::*;
(
    input  logic [ENT_W-1:0]  entry,
    input  logic [LVL_W-1:0]  lvl,
    input  logic              is_write,
    output logic              descend,
    output logic              leaf,
    output logic              fault,
    output logic [CODE_W-1:0] code,
    output logic              need_wb,
    output logic [ENT_W-1:0]  wb_data,
    output logic [ACC_W-1:0]  acc
);
    ent_type_e etype;
    logic [2:0] fkind;

    assign etype = ent_type_e'(entry[1:0]);

    // Pointers are followed below level 3; leaves count below the context table.
    always_comb begin
        descend = (etype == ET_PTR)  && (lvl != LVL_W'(LAST_LVL));
        leaf    = (etype == ET_LEAF) && (lvl != '0);
        fault   = !descend && !leaf;
    end

    // Fault kind: invalid entry versus every other stop.
    assign fkind = (etype == ET_INVALID) ? FK_INVALID : FK_ERROR;
    assign code  = {lvl, 3'b000, fkind, 2'b00};

    // Referenced/modified update and the value written back.
    always_comb begin
        need_wb = leaf && (!entry[BIT_REF] || (is_write && !entry[BIT_MOD]));
        wb_data = entry;
        wb_data[BIT_REF] = 1'b1;
        if (is_write) wb_data[BIT_MOD] = 1'b1;
    end

    assign acc = entry[ACC_LO +: ACC_W];
endmodule

// File: rtl/xlat_phys.sv
// Physical address composer.
// Adds the page offset chosen by the leaf level to the page base.
// Assumes lvl is 1 (16 MB), 2 (256 KB) or 3 (4 KB).
module xlat_phys
    import xlat_walker_pkg::*;
(
    input  logic [PPN_W-1:0] ppn,
    input  logic [LVL_W-1:0] lvl,
    input  logic [23:0]      va_lo,
    output logic [PA_W-1:0]  paddr
);
    logic [23:0] ofs;

    // Offset width follows the page size of the leaf level.
    always_comb begin
        case (lvl)
            2'd1:    ofs = va_lo;
            2'd2:    ofs = {6'd0, va_lo[17:0]};
            default: ofs = {12'd0, va_lo[11:0]};
        endcase
    end

    // Page base is the address field scaled by 4 bits plus the 4 KB granule.
    assign paddr = {ppn, 12'h000} + PA_W'(ofs);
endmodule

// File: rtl/xlat_walker.sv
// Three-level page table walker, top level.
// Accepts one request while idle. It bypasses when translation is off.
// Otherwise it reads the context word and up to three table words over
// a req/ack port, writes back the referenced/modified bits and pulses done.
// Assumes the memory holds mem_req until it returns mem_ack for one edge.
module xlat_walker
    import xlat_walker_pkg::*;
#(
    parameter int CTX_W  = 8,
    parameter int BOOT_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_boot,
    input  logic [31:0]       cfg_root,
    input  logic [CTX_W-1:0]  cfg_ctx,
    input  logic [35:0]       cfg_prom_base,
    input  logic              req_valid,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    input  logic              req_fetch,
    output logic              busy,
    output logic              done,
    output logic              rsp_fault,
    output logic [9:0]        rsp_code,
    output logic [1:0]        rsp_kind,
    output logic [1:0]        rsp_level,
    output logic [2:0]        rsp_acc,
    output logic [35:0]       rsp_paddr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [35:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    walk_state_e       state;
    logic [LVL_W-1:0]  lvl;
    logic [LVL_W-1:0]  lvl_next;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;

    logic [PA_W-1:0]   ctx_addr;
    logic [PA_W-1:0]   next_addr;
    logic              d_descend, d_leaf, d_fault, d_need_wb;
    logic [CODE_W-1:0] d_code;
    logic [ENT_W-1:0]  d_wb_data;
    logic [ACC_W-1:0]  d_acc;
    logic [PA_W-1:0]   leaf_paddr;
    logic [PA_W-1:0]   boot_paddr;

    assign lvl_next   = lvl + 2'd1;
    assign busy       = (state != WS_IDLE);
    assign boot_paddr = cfg_prom_base | PA_W'(req_vaddr[BOOT_W-1:0]);

    xlat_addr_gen #(.CTX_W(CTX_W)) addr_i (
        .root      (cfg_root),
        .ctx       (cfg_ctx),
        .ptr       (mem_rdata[ENT_W-1:2]),
        .lvl_next  (lvl_next),
        .va_hi     (va_q[VA_W-1:12]),
        .ctx_addr  (ctx_addr),
        .next_addr (next_addr)
    );

    xlat_entry_dec dec_i (
        .entry    (mem_rdata),
        .lvl      (lvl),
        .is_write (wr_q),
        .descend  (d_descend),
        .leaf     (d_leaf),
        .fault    (d_fault),
        .code     (d_code),
        .need_wb  (d_need_wb),
        .wb_data  (d_wb_data),
        .acc      (d_acc)
    );

    xlat_phys phys_i (
        .ppn   (mem_rdata[ENT_W-1:PPN_LO]),
        .lvl   (lvl),
        .va_lo (va_q[23:0]),
        .paddr (leaf_paddr)
    );

    // Walk sequencer: accept, step per level, optional write-back, strobe done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WS_IDLE;
            lvl       <= '0;
            va_q      <= '0;
            wr_q      <= 1'b0;
            done      <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_code  <= '0;
            rsp_kind  <= RK_WALK;
            rsp_level <= '0;
            rsp_acc   <= '0;
            rsp_paddr <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (req_valid && !cfg_enable) begin
                        done      <= 1'b1;
                        rsp_fault <= 1'b0;
                        rsp_code  <= '0;
                        rsp_level <= '0;
                        rsp_acc   <= '0;
                        if (cfg_boot && req_fetch) begin
                            rsp_kind  <= RK_BOOT;
                            rsp_paddr <= boot_paddr;
                        end else begin
                            rsp_kind  <= RK_FULL;
                            rsp_paddr <= PA_W'(req_vaddr);
                        end
                    end else if (req_valid) begin
                        state    <= WS_READ;
                        lvl      <= '0;
                        va_q     <= req_vaddr;
                        wr_q     <= req_write;
                        mem_req  <= 1'b1;
                        mem_we   <= 1'b0;
                        mem_addr <= ctx_addr;
                    end
                end
                WS_READ: begin
                    if (mem_ack) begin
                        if (d_descend) begin
                            lvl      <= lvl_next;
                            mem_addr <= next_addr;
                        end else begin
                            rsp_kind  <= RK_WALK;
                            rsp_fault <= d_fault;
                            rsp_code  <= d_fault ? d_code : '0;
                            rsp_level <= d_leaf ? lvl : '0;
                            rsp_acc   <= d_leaf ? d_acc : '0;
                            rsp_paddr <= d_leaf ? leaf_paddr : '0;
                            if (d_need_wb) begin
                                state     <= WS_WRITE;
                                mem_we    <= 1'b1;
                                mem_wdata <= d_wb_data;
                            end else begin
                                state   <= WS_IDLE;
                                mem_req <= 1'b0;
                                done    <= 1'b1;
                            end
                        end
                    end
                end
                WS_WRITE: begin
                    if (mem_ack) begin
                        state   <= WS_IDLE;
                        mem_req <= 1'b0;
                        mem_we  <= 1'b0;
                        done    <= 1'b1;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xlat_walker_chk.sv
// Protocol and result checker for the page table walker.
// Relates the memory port, busy, done and the result fields over time.
module xlat_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        rsp_fault,
    input logic [9:0]  rsp_code,
    input logic [1:0]  rsp_kind,
    input logic [1:0]  rsp_level,
    input logic        mem_req,
    input logic        mem_we,
    input logic [35:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack
);
    // R10: an access waiting for ack keeps every field steady.
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    // R10: the port is quiet outside a walk.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R11: a walk only ends together with its done strobe.
    a_r11_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6, R11: a finished write-back closes the walk on the next cycle.
    a_r6_wb_closes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> done && !busy);

    // R6: every written word carries the referenced bit.
    a_r6_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[5]);

    // R5: fault codes carry a level, a kind of 1 or 4, and zero elsewhere.
    a_r5_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
        done && rsp_fault |-> (rsp_code[1:0] == 2'b00) && (rsp_code[7:5] == 3'b000)
                              && ((rsp_code[4:2] == 3'd1) || (rsp_code[4:2] == 3'd4)));

    // R4: a successful walk reports the level of its leaf.
    a_r4_leaf_level: assert property (@(posedge clk) disable iff (!rst_n)
        done && !rsp_fault && (rsp_kind == 2'd0) |-> (rsp_level != 2'd0));
endmodule

bind xlat_walker xlat_walker_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rsp_fault (rsp_fault),
    .rsp_code  (rsp_code),
    .rsp_kind  (rsp_kind),
    .rsp_level (rsp_level),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/xlat_walker_tb_top.sv
// Bench for the page table walker: a table of walk vectors over a fixed
// set of translation tables, then directed reset, bypass, stall and busy tests.
module xlat_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1;
    logic        cfg_boot = 1'b0;
    logic [31:0] cfg_root = 32'h10;
    logic [7:0]  cfg_ctx = 8'd1;
    logic [35:0] cfg_prom_base = 36'hFF000_0000;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic        busy, done, rsp_fault;
    logic [9:0]  rsp_code;
    logic [1:0]  rsp_kind, rsp_level;
    logic [2:0]  rsp_acc;
    logic [35:0] rsp_paddr;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    xlat_walker dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_boot(cfg_boot),
        .cfg_root(cfg_root), .cfg_ctx(cfg_ctx), .cfg_prom_base(cfg_prom_base),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_fetch(req_fetch), .busy(busy), .done(done), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .rsp_kind(rsp_kind), .rsp_level(rsp_level),
        .rsp_acc(rsp_acc), .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    int errs = 0;
    int checks = 0;

    // Memory model state and traffic counters.
    logic [31:0] mem [0:4095];
    int          stall = 0;
    int          wait_cnt = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [35:0] first_raddr = '0;
    logic [35:0] last_raddr = '0;
    logic [35:0] last_waddr = '0;
    logic [31:0] last_wdata = '0;
    int          cyc = 0;

    typedef struct packed {
        logic [7:0]  ctx;
        logic [31:0] va;
        logic        wr;
        logic        flt;
        logic [9:0]  code;
        logic [35:0] pa;
        logic [2:0]  acc;
        logic [1:0]  lvl;
        logic [2:0]  rds;
        logic        wb;
        logic [31:0] wdat;
        logic [35:0] last;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VT [0:NV-1] = '{
        '{8'd1, 32'h01AB_CDEF, 1'b0, 1'b0, 10'h000, 36'hF00ABCDEF, 3'd2, 2'd1, 3'd2, 1'b1, 32'hF000002A, 36'h404},
        '{8'd1, 32'h01AB_CDEF, 1'b1, 1'b0, 10'h000, 36'hF00ABCDEF, 3'd2, 2'd1, 3'd2, 1'b1, 32'hF000006A, 36'h404},
        '{8'd1, 32'h0100_0000, 1'b0, 1'b0, 10'h000, 36'hF00000000, 3'd2, 2'd1, 3'd2, 1'b0, 32'h0, 36'h404},
        '{8'd1, 32'h0005_6789, 1'b0, 1'b0, 10'h000, 36'h0ABCF4789, 3'd5, 2'd2, 3'd3, 1'b0, 32'h0, 36'h804},
        '{8'd1, 32'h0000_0123, 1'b0, 1'b0, 10'h000, 36'h000077123, 3'd7, 2'd3, 3'd4, 1'b0, 32'h0, 36'hC00},
        '{8'd1, 32'h0000_1FFF, 1'b0, 1'b0, 10'h000, 36'h001234FFF, 3'd1, 2'd3, 3'd4, 1'b1, 32'h00123426, 36'hC04},
        '{8'd1, 32'h0000_5000, 1'b1, 1'b0, 10'h000, 36'h0000AB000, 3'd3, 2'd3, 3'd4, 1'b1, 32'h0000AB6E, 36'hC14},
        '{8'd1, 32'h0000_2000, 1'b0, 1'b1, 10'h304, 36'h0, 3'd0, 2'd0, 3'd4, 1'b0, 32'h0, 36'hC08},
        '{8'd1, 32'h0000_3000, 1'b0, 1'b1, 10'h310, 36'h0, 3'd0, 2'd0, 3'd4, 1'b0, 32'h0, 36'hC0C},
        '{8'd1, 32'h0000_4000, 1'b0, 1'b1, 10'h310, 36'h0, 3'd0, 2'd0, 3'd4, 1'b0, 32'h0, 36'hC10},
        '{8'd1, 32'h0008_0000, 1'b0, 1'b1, 10'h204, 36'h0, 3'd0, 2'd0, 3'd3, 1'b0, 32'h0, 36'h808},
        '{8'd1, 32'h000C_0000, 1'b0, 1'b1, 10'h210, 36'h0, 3'd0, 2'd0, 3'd3, 1'b0, 32'h0, 36'h80C},
        '{8'd1, 32'h0200_0000, 1'b0, 1'b1, 10'h104, 36'h0, 3'd0, 2'd0, 3'd2, 1'b0, 32'h0, 36'h408},
        '{8'd1, 32'h0300_0000, 1'b0, 1'b1, 10'h110, 36'h0, 3'd0, 2'd0, 3'd2, 1'b0, 32'h0, 36'h40C},
        '{8'd0, 32'h0000_0000, 1'b0, 1'b1, 10'h004, 36'h0, 3'd0, 2'd0, 3'd1, 1'b0, 32'h0, 36'h100},
        '{8'd2, 32'h0000_0000, 1'b0, 1'b1, 10'h010, 36'h0, 3'd0, 2'd0, 3'd1, 1'b0, 32'h0, 36'h108},
        '{8'd3, 32'h0000_0000, 1'b0, 1'b1, 10'h010, 36'h0, 3'd0, 2'd0, 3'd1, 1'b0, 32'h0, 36'h10C}
    };

    // Table contents, then a word memory with a fixed stall before each ack.
    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        mem[12'h041] = 32'h0000_0041;
        mem[12'h042] = 32'h0000_0002;
        mem[12'h043] = 32'h0000_0003;
        mem[12'h100] = 32'h0000_0081;
        mem[12'h101] = 32'hF000_000A;
        mem[12'h103] = 32'h0000_0003;
        mem[12'h200] = 32'h0000_00C1;
        mem[12'h201] = 32'h0ABC_DE76;
        mem[12'h203] = 32'h0000_0003;
        mem[12'h300] = 32'h0000_777E;
        mem[12'h301] = 32'h0012_3406;
        mem[12'h303] = 32'h0000_0C01;
        mem[12'h304] = 32'h0000_0003;
        mem[12'h305] = 32'h0000_AB2E;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                if (wait_cnt < stall) begin
                    wait_cnt = wait_cnt + 1;
                    mem_ack = 1'b0;
                end else begin
                    wait_cnt = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr[13:2]] = mem_wdata;
                        wr_cnt = wr_cnt + 1;
                        last_waddr = mem_addr;
                        last_wdata = mem_wdata;
                    end else begin
                        mem_rdata = mem[mem_addr[13:2]];
                        rd_cnt = rd_cnt + 1;
                        if (rd_cnt == 1) first_raddr = mem_addr;
                        last_raddr = mem_addr;
                    end
                end
            end else begin
                mem_ack = 1'b0;
                wait_cnt = 0;
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request from a falling edge; count edges until done is seen.
    task automatic run_req(input logic [31:0] va, input logic wr, input logic fe,
                           input logic intrude);
        rd_cnt = 0;
        wr_cnt = 0;
        req_vaddr = va;
        req_write = wr;
        req_fetch = fe;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cyc = 1;
        if (intrude) begin
            req_vaddr = 32'h0300_0000;
            req_write = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        while (!done && cyc < 200) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        check("R11 done arrives", {63'd0, done}, 64'd1);
    endtask

    localparam int WD_LIMIT = 150000;
    int wd = 0;

    // Watchdog: an over-long run counts as one failed check.
    initial begin
        while (wd < WD_LIMIT) begin
            @(posedge clk);
            wd++;
        end
        errs++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", wd, WD_LIMIT);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 busy in reset", {63'd0, busy}, 64'd0);
        check("R1 done in reset", {63'd0, done}, 64'd0);
        check("R1 mem_req in reset", {63'd0, mem_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", {63'd0, busy}, 64'd0);

        // Vector table: walks over all levels, leaves and faults.
        for (int v = 0; v < NV; v++) begin
            cfg_enable = 1'b1;
            cfg_ctx = VT[v].ctx;
            run_req(VT[v].va, VT[v].wr, 1'b0, 1'b0);
            check("R5 fault flag", {63'd0, rsp_fault}, {63'd0, VT[v].flt});
            check("R5 fault code", {54'd0, rsp_code}, {54'd0, VT[v].code});
            check("R8 kind is walk", {62'd0, rsp_kind}, 64'd0);
            if (!VT[v].flt) begin
                check("R4 paddr", {28'd0, rsp_paddr}, {28'd0, VT[v].pa});
                check("R4 level", {62'd0, rsp_level}, {62'd0, VT[v].lvl});
                check("R12 access field", {61'd0, rsp_acc}, {61'd0, VT[v].acc});
            end
            check("R3 reads per walk", rd_cnt, {61'd0, VT[v].rds});
            check("R2 first address", {28'd0, first_raddr},
                  64'h100 + {54'd0, VT[v].ctx, 2'b00});
            check("R2 last address", {28'd0, last_raddr}, {28'd0, VT[v].last});
            check("R6 write count", wr_cnt, {63'd0, VT[v].wb});
            if (VT[v].wb) begin
                check("R6 write data", {32'd0, last_wdata}, {32'd0, VT[v].wdat});
                check("R6 write address", {28'd0, last_waddr}, {28'd0, VT[v].last});
            end
            check("R11 cycles to done", cyc, 64'd1 + {61'd0, VT[v].rds} + {63'd0, VT[v].wb});
            check("R11 busy low at done", {63'd0, busy}, 64'd0);
            @(negedge clk);
            check("R11 done one cycle", {63'd0, done}, 64'd0);
        end

        // R7: translation off gives the address back with full permission.
        cfg_enable = 1'b0;
        cfg_boot = 1'b0;
        run_req(32'h89AB_CDEF, 1'b0, 1'b1, 1'b0);
        check("R7 pass paddr", {28'd0, rsp_paddr}, 64'h0_89AB_CDEF);
        check("R7 pass kind", {62'd0, rsp_kind}, 64'd1);
        check("R7 no memory reads", rd_cnt, 64'd0);
        check("R11 pass cycles", cyc, 64'd1);

        // R8: boot redirect applies to fetches only.
        cfg_boot = 1'b1;
        run_req(32'h1234_5678, 1'b0, 1'b1, 1'b0);
        check("R8 boot paddr", {28'd0, rsp_paddr}, 64'hF_F004_5678);
        check("R8 boot kind", {62'd0, rsp_kind}, 64'd2);
        run_req(32'h1234_5678, 1'b0, 1'b0, 1'b0);
        check("R8 data not redirected", {28'd0, rsp_paddr}, 64'h0_1234_5678);
        check("R8 data kind", {62'd0, rsp_kind}, 64'd1);

        // R10: stalled memory; boot setting has no effect while enabled.
        cfg_enable = 1'b1;
        cfg_ctx = 8'd1;
        stall = 2;
        run_req(32'h0005_6789, 1'b0, 1'b1, 1'b0);
        check("R10 stalled paddr", {28'd0, rsp_paddr}, 64'h0_ABCF_4789);
        check("R8 enabled ignores boot", {62'd0, rsp_kind}, 64'd0);
        check("R10 stalled cycles", cyc, 64'd10);
        check("R10 stalled reads", rd_cnt, 64'd3);
        stall = 0;
        cfg_boot = 1'b0;

        // R9: a second request during a walk is ignored.
        run_req(32'h0000_0123, 1'b0, 1'b0, 1'b1);
        check("R9 result kept", {28'd0, rsp_paddr}, 64'h0_0007_7123);
        check("R9 fault not taken", {63'd0, rsp_fault}, 64'd0);
        check("R9 reads unchanged", rd_cnt, 64'd4);
        check("R9 no write", wr_cnt, 64'd0);
        begin
            int extra = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R9 no extra done", extra, 64'd0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule